// File: doc/BRIEF.md
# Cross-Domain CPU Event Pulse Generator

This block collects per-line CPU event strobes, which arrive already qualified by their event masks, and turns them into one wake event for a processor that runs on its own free-running clock. Any strobe sets a single request level in the bus clock domain. The CPU clock domain synchronises that level and fires a one-cycle event pulse. It then returns a one-cycle clear, which resets the level asynchronously. This closes a four-phase handshake across two unrelated clocks.

Requests that land while the level is already high fold into the event in progress. The block keeps no pending flag, so after the handshake nothing remains that software could see. Once the CPU side has flushed the old level out of its synchroniser, a later request starts a new handshake.

Top module: `cpu_evt_pulse_gen`

## Requirements
- R1: After reset, `evt_level`, `cpu_evt_pulse` and `evt_clear` are all 0.
- R2: A 1 on any bit of `line_evt` at a rising `bus_clk` edge sets `evt_level` at that edge. The level never rises without such a strobe.
- R3: Each isolated request yields exactly one `cpu_evt_pulse`, and the pulse is high for exactly one `cpu_clk` cycle.
- R4: `evt_clear` is high for exactly one `cpu_clk` cycle, in the cycle right after the pulse. It never coincides with the pulse.
- R5: While `evt_clear` is high, `evt_level` is 0, and the level stays low once the handshake ends.
- R6: Strobes that arrive while `evt_level` is already high, from the same or other lines, merge into the event in progress and produce no extra pulse.
- R7: Strobes on several lines in the same `bus_clk` cycle produce one pulse.
- R8: No state outlives the handshake. With no further strobes, no further pulse appears. A request made after the handshake produces a new pulse.
- R9: R3 to R5 hold whether `cpu_clk` is faster than, slower than, or close to `bus_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; the request level is set on its rising edge |
| bus_rst_n | input | 1 | Active-low asynchronous reset of the bus-side latch |
| cpu_clk | input | 1 | Free-running CPU clock |
| cpu_rst_n | input | 1 | Active-low asynchronous reset of the CPU-side logic |
| line_evt | input | NUM_LINES | Masked per-line CPU event strobes, synchronous to bus_clk |
| evt_level | output | 1 | High-level event request toward the CPU side |
| cpu_evt_pulse | output | 1 | One-cycle event pulse, synchronous to cpu_clk |
| evt_clear | output | 1 | One-cycle clear of the request level, synchronous to cpu_clk |

## Verification
The assertions assume that `line_evt` changes only away from the rising edge of `bus_clk`, and that both resets are released while the strobes are quiet. The stimulus drives strobes on the falling edge of `bus_clk`, holds them for one full cycle, and releases reset before any strobe. The properties that cross domains also assume the clear comes only from the CPU-side generator. The bench keeps this by observing the clear and never driving it.

// File: rtl/evg_pkg.sv
package evg_pkg;

  typedef enum logic [1:0] {
    EVG_IDLE  = 2'd0,
    EVG_FIRE  = 2'd1,
    EVG_CLEAR = 2'd2,
    EVG_FLUSH = 2'd3
  } evg_state_t;

  // cycles spent after the clear before the synchroniser output is trusted again
  function automatic int unsigned flush_cycles(input int unsigned stages);
    return stages;
  endfunction

  // cpu cycles from a stable level to the end of a full handshake
  function automatic int unsigned handshake_cycles(input int unsigned stages);
    return stages + 2 + flush_cycles(stages) + 1;
  endfunction

endpackage

// File: rtl/evg_level_latch.sv
module evg_level_latch #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 bus_clk,
  input  logic                 bus_rst_n,
  input  logic                 clr_async,
  input  logic [NUM_LINES-1:0] line_evt,
  output logic                 any_req,
  output logic                 level
);

  assign any_req = |line_evt;

  always_ff @(posedge bus_clk or negedge bus_rst_n or posedge clr_async) begin
    if (!bus_rst_n)     level <= 1'b0;
    else if (clr_async) level <= 1'b0;
    else if (any_req)   level <= 1'b1;
  end

  // R2: a rise of the level is always caused by a strobe at the previous edge
  a_r2_rise_needs_strobe: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(level) |-> $past(any_req));

endmodule

// File: rtl/evg_sync.sv
module evg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];

endmodule

// File: rtl/evg_pulse_fsm.sv
module evg_pulse_fsm
  import evg_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic cpu_clk,
  input  logic cpu_rst_n,
  input  logic lvl_sync,
  output logic pulse,
  output logic clear,
  output logic flush_done
);

  localparam int unsigned FLUSH_LEN = flush_cycles(STAGES);
  localparam int unsigned CW        = $clog2(FLUSH_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FLUSH_LEN - 1);

  evg_state_t    state, state_nx;
  logic [CW-1:0] cnt;

  assign flush_done = (state == EVG_FLUSH) && (cnt == CNT_LAST);

  always_comb begin
    state_nx = state;
    unique case (state)
      EVG_IDLE:  if (lvl_sync) state_nx = EVG_FIRE;
      EVG_FIRE:  state_nx = EVG_CLEAR;
      EVG_CLEAR: state_nx = EVG_FLUSH;
      EVG_FLUSH: if (flush_done) state_nx = EVG_IDLE;
      default:   state_nx = EVG_IDLE;
    endcase
  end

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      state <= EVG_IDLE;
      cnt   <= '0;
      pulse <= 1'b0;
      clear <= 1'b0;
    end else begin
      state <= state_nx;
      cnt   <= (state == EVG_FLUSH) ? cnt + 1'b1 : '0;
      pulse <= (state_nx == EVG_FIRE);
      clear <= (state_nx == EVG_CLEAR);
    end
  end

  // R3: the event pulse lasts a single cpu cycle
  a_r3_pulse_one_cycle: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    pulse |=> !pulse);

  // R4: the clear follows the pulse, lasts one cycle, and never overlaps it
  a_r4_clear_after_pulse: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    pulse |=> clear);
  a_r4_clear_one_cycle: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    clear |=> !clear);
  a_r4_disjoint: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    $onehot0({pulse, clear}));

endmodule

// File: rtl/cpu_evt_pulse_gen.sv
module cpu_evt_pulse_gen #(
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 bus_clk,
  input  logic                 bus_rst_n,
  input  logic                 cpu_clk,
  input  logic                 cpu_rst_n,
  input  logic [NUM_LINES-1:0] line_evt,
  output logic                 evt_level,
  output logic                 cpu_evt_pulse,
  output logic                 evt_clear
);

  logic any_req;
  logic lvl_sync;
  logic flush_done;

  evg_level_latch #(.NUM_LINES(NUM_LINES)) u_latch (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .clr_async (evt_clear),
    .line_evt  (line_evt),
    .any_req   (any_req),
    .level     (evt_level)
  );

  evg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (cpu_clk),
    .rst_n (cpu_rst_n),
    .d     (evt_level),
    .q     (lvl_sync)
  );

  evg_pulse_fsm #(.STAGES(SYNC_STAGES)) u_fsm (
    .cpu_clk    (cpu_clk),
    .cpu_rst_n  (cpu_rst_n),
    .lvl_sync   (lvl_sync),
    .pulse      (cpu_evt_pulse),
    .clear      (evt_clear),
    .flush_done (flush_done)
  );

  // R5: the level is held low for as long as the clear is asserted
  a_r5_level_low_in_clear: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n || !bus_rst_n)
    evt_clear |-> !evt_level);

  // R3: a pulse only fires from a synchronised request
  a_r3_pulse_needs_level: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    $rose(cpu_evt_pulse) |-> $past(lvl_sync));

endmodule

// File: tb/cpu_evt_pulse_gen_test.sv
`timescale 1ns/1ps
module cpu_evt_pulse_gen_test;

  localparam int NL = 8;

  logic          bus_clk = 1'b0;
  logic          cpu_clk = 1'b0;
  logic          bus_rst_n = 1'b0;
  logic          cpu_rst_n = 1'b0;
  logic [NL-1:0] line_evt = '0;
  logic          evt_level, cpu_evt_pulse, evt_clear;

  realtime cpu_half = 3.1;
  int checks = 0;
  int errors = 0;

  int  pulse_cnt = 0, clear_cnt = 0, width_err = 0, order_err = 0;
  logic prev_pulse = 1'b0, prev_clear = 1'b0;

  always #4 bus_clk = ~bus_clk;
  always #(cpu_half) cpu_clk = ~cpu_clk;

  cpu_evt_pulse_gen #(.NUM_LINES(NL), .SYNC_STAGES(2)) uut (
    .bus_clk, .bus_rst_n, .cpu_clk, .cpu_rst_n, .line_evt,
    .evt_level, .cpu_evt_pulse, .evt_clear
  );

  // observe cpu-domain outputs mid-cycle
  always @(negedge cpu_clk) begin
    if (cpu_rst_n) begin
      if (cpu_evt_pulse) pulse_cnt++;
      if (evt_clear) clear_cnt++;
      if ((cpu_evt_pulse && prev_pulse) || (evt_clear && prev_clear)) width_err++;
      if ((evt_clear && !prev_pulse) || (cpu_evt_pulse && evt_clear)) order_err++;
    end
    prev_pulse = cpu_evt_pulse;
    prev_clear = evt_clear;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [NL-1:0] v);
    @(negedge bus_clk); line_evt = v;
    @(negedge bus_clk); line_evt = '0;
  endtask

  task automatic settle();
    repeat (90) @(negedge bus_clk);
  endtask

  task automatic t_reset();
    check(evt_level == 0, "R1 level", evt_level, 0);
    check(cpu_evt_pulse == 0, "R1 pulse", cpu_evt_pulse, 0);
    check(evt_clear == 0, "R1 clear", evt_clear, 0);
  endtask

  task automatic t_isolated(input int line, input string tag);
    int p0 = pulse_cnt, c0 = clear_cnt;
    strobe(NL'(1) << line);
    check(evt_level == 1, {"R2 level set ", tag}, evt_level, 1);
    settle();
    check(pulse_cnt - p0 == 1, {"R3 one pulse ", tag}, pulse_cnt - p0, 1);
    check(clear_cnt - c0 == 1, {"R4 one clear ", tag}, clear_cnt - c0, 1);
    check(evt_level == 0, {"R5 level low ", tag}, evt_level, 0);
  endtask

  task automatic t_merge();
    int p0 = pulse_cnt;
    @(negedge bus_clk); line_evt = 8'h02;
    @(negedge bus_clk); line_evt = 8'h04;
    check(evt_level == 1, "R6 level high during merge", evt_level, 1);
    @(negedge bus_clk); line_evt = 8'h02;
    @(negedge bus_clk); line_evt = '0;
    settle();
    check(pulse_cnt - p0 == 1, "R6 merged pulses", pulse_cnt - p0, 1);
    check(evt_level == 0, "R6 level low after merge", evt_level, 0);
  endtask

  task automatic t_simultaneous();
    int p0 = pulse_cnt;
    strobe(8'hA5);
    settle();
    check(pulse_cnt - p0 == 1, "R7 simultaneous lines", pulse_cnt - p0, 1);
  endtask

  task automatic t_no_residue();
    int p0 = pulse_cnt;
    repeat (200) @(negedge bus_clk);
    check(pulse_cnt == p0, "R8 no pulse without request", pulse_cnt - p0, 0);
    check(evt_level == 0, "R8 level stays low", evt_level, 0);
    strobe(8'h80);
    settle();
    check(pulse_cnt - p0 == 1, "R8 new request after handshake", pulse_cnt - p0, 1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge bus_clk);
    bus_rst_n = 1'b1;
    cpu_rst_n = 1'b1;
    repeat (3) @(negedge bus_clk);
    t_reset();
    cpu_half = 3.1;  t_isolated(0, "R9 fast cpu");
    cpu_half = 4.35; t_isolated(3, "R9 near cpu");
    cpu_half = 23.0; t_isolated(7, "R9 slow cpu");
    t_merge();
    cpu_half = 5.7;  t_simultaneous();
    t_no_residue();
    check(width_err == 0, "R3 R4 widths", width_err, 0);
    check(order_err == 0, "R4 clear order", order_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule